// File: doc/BRIEF.md
# Ring-Trip Duty-Cycle Detector

While a subscriber line is being rung, the analog front end reports loop state on one digital detector bit. A high level means the line is on-hook and a low level means it has tripped. The detector input is only partly filtered, so during ringing the bit can toggle at the ringing frequency. No single sample can be trusted. This block makes the off-hook decision from the share of time the bit spends low.

A host asserts a ringing request. The block then enables the ring relay drive and counts low samples of the synchronized detector bit over consecutive observation windows of fixed length. If low samples form a strict majority of a window, the block decides the subscriber has answered. It removes the relay enable, raises a latched off-hook flag and emits a one-cycle trip pulse. The latched condition is held until the host withdraws its request. Outside ringing the detector bit is not used.

Top module: `ring_trip_detector`

## Requirements
- R1: After reset, `relayEn`, `offHook` and `ringTrip` are all 0 and no ringing is in progress.
- R2: When `ringReq` is high at a clock edge while the block is idle, `relayEn` is 1 after that edge. `relayEn` is never 1 after an edge at which `ringReq` was low.
- R3: `detIn` passes through a two-flop synchronizer. The sample counted at a clock edge is the level `detIn` had two edges earlier.
- R4: An observation window is `WINDOW_CYCLES` consecutive samples. The first sample is taken at the edge after ringing starts. Counts restart at every window boundary.
- R5: A window ends in a trip only when its low-sample count is strictly greater than `WINDOW_CYCLES`/2. An exact tie is treated as on-hook.
- R6: At the edge that closes a tripping window, `relayEn` goes to 0 and `offHook` goes to 1 together with `ringTrip`. `relayEn` and `offHook` are never both 1.
- R7: `ringTrip` is high for exactly one cycle per trip decision.
- R8: After a trip, `offHook` stays 1 and `relayEn` stays 0 as long as `ringReq` stays high. The edge at which `ringReq` is low returns both outputs to 0.
- R9: While not ringing, `detIn` has no effect. A low detector while idle never sets `offHook`.
- R10: Dropping `ringReq` in the middle of a window discards that window's partial counts. A later ringing request starts from zero counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| detIn | input | 1 | Asynchronous loop detector bit (1 = on-hook, 0 = tripped) |
| ringReq | input | 1 | Host request to ring the line |
| relayEn | output | 1 | Ring relay drive enable |
| offHook | output | 1 | Latched off-hook indication after a trip |
| ringTrip | output | 1 | One-cycle pulse on the trip decision |

## Verification
The hardest case to reach from the ports is a window whose low count sits right at the majority threshold. It has to be placed exactly relative to the window start and the two-cycle synchronizer delay. Directed windows put runs of 20 and 21 low levels at chosen offsets after the request rises. Shifting a run by one cycle moves one low sample across the window edge. This separates the tie, the strict majority and the synchronizer latency. Random bursts with varied low-duty percentages and early request drops cover the other paths, and a cycle model in the bench checks them.

// File: rtl/ringtrip_pkg.sv
package ringtrip_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RING = 2'd1,
    ST_TRIP = 2'd2
  } ringState_t;

  typedef struct packed {
    logic sampleEn;
    logic clearWin;
  } dpStrobe_t;

endpackage

// File: rtl/rtd_datapath.sv
module rtd_datapath
  import ringtrip_pkg::*;
#(
  parameter int WINDOW_CYCLES = 1000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      detRaw,
  input  dpStrobe_t strobe,
  output logic      windowEnd,
  output logic      majorityLow
);
  localparam int CW = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(WINDOW_CYCLES - 1);
  localparam logic [CW:0]   WIN_LEN  = (CW+1)'(WINDOW_CYCLES);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   detSync;
  logic                   lowSample;
  logic [CW-1:0]          winCnt;
  logic [CW-1:0]          lowCnt;
  logic [CW-1:0]          lowTotal;

  // synchronizer chain, reset to the on-hook level
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= detRaw;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], detRaw};
      end
    end
  endgenerate

  assign detSync     = syncQ[SYNC_STAGES-1];
  assign lowSample   = strobe.sampleEn & ~detSync;
  assign windowEnd   = strobe.sampleEn && (winCnt == LAST_IDX);
  assign lowTotal    = lowCnt + CW'(lowSample);
  assign majorityLow = ({1'b0, lowTotal} << 1) > WIN_LEN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
      lowCnt <= '0;
    end else if (strobe.clearWin || windowEnd) begin
      winCnt <= '0;
      lowCnt <= '0;
    end else if (strobe.sampleEn) begin
      winCnt <= winCnt + 1'b1;
      lowCnt <= lowTotal;
    end
  end

endmodule

// File: rtl/rtd_control.sv
module rtd_control
  import ringtrip_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ringReq,
  input  logic      windowEnd,
  input  logic      majorityLow,
  output dpStrobe_t strobe,
  output logic      relayEn,
  output logic      offHook,
  output logic      ringTrip
);
  ringState_t state, stateNext;
  logic       tripNow;
  logic       tripQ;

  assign tripNow = (state == ST_RING) && ringReq && windowEnd && majorityLow;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (ringReq) stateNext = ST_RING;
      ST_RING: begin
        if (!ringReq)     stateNext = ST_IDLE;
        else if (tripNow) stateNext = ST_TRIP;
      end
      ST_TRIP: if (!ringReq) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      tripQ <= 1'b0;
    end else begin
      state <= stateNext;
      tripQ <= tripNow;
    end
  end

  assign strobe.sampleEn = (state == ST_RING);
  assign strobe.clearWin = (state != ST_RING);
  assign relayEn         = (state == ST_RING);
  assign offHook         = (state == ST_TRIP);
  assign ringTrip        = tripQ;

endmodule

// File: rtl/ring_trip_detector.sv
module ring_trip_detector
  import ringtrip_pkg::*;
#(
  parameter int WINDOW_CYCLES = 1000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic detIn,
  input  logic ringReq,
  output logic relayEn,
  output logic offHook,
  output logic ringTrip
);
  dpStrobe_t strobe;
  logic      windowEnd;
  logic      majorityLow;

  rtd_datapath #(
    .WINDOW_CYCLES(WINDOW_CYCLES),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .detRaw     (detIn),
    .strobe     (strobe),
    .windowEnd  (windowEnd),
    .majorityLow(majorityLow)
  );

  rtd_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .ringReq    (ringReq),
    .windowEnd  (windowEnd),
    .majorityLow(majorityLow),
    .strobe     (strobe),
    .relayEn    (relayEn),
    .offHook    (offHook),
    .ringTrip   (ringTrip)
  );

endmodule

// File: rtl/rtd_checker.sv
module rtd_checker (
  input logic clk,
  input logic rstN,
  input logic ringReq,
  input logic relayEn,
  input logic offHook,
  input logic ringTrip
);

  AST_TRIP_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    ringTrip |=> !ringTrip); // R7

  AST_TRIP_DROPS_RELAY: assert property (@(posedge clk) disable iff (!rstN)
    ringTrip |-> (!relayEn && offHook)); // R6

  AST_RELAY_OFFHOOK_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(relayEn && offHook)); // R6

  AST_NO_RELAY_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !ringReq |=> !relayEn); // R2

  AST_OFFHOOK_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (offHook && ringReq) |=> offHook); // R8

  AST_OFFHOOK_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    !ringReq |=> !offHook); // R8

  AST_TRIP_ONLY_WHILE_RINGING: assert property (@(posedge clk) disable iff (!rstN)
    $rose(offHook) |-> $past(relayEn)); // R9

endmodule

bind ring_trip_detector rtd_checker u_rtdChk (
  .clk     (clk),
  .rstN    (rstN),
  .ringReq (ringReq),
  .relayEn (relayEn),
  .offHook (offHook),
  .ringTrip(ringTrip)
);

// File: tb/ring_trip_detector_bench.sv
module ring_trip_detector_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 40;
  localparam int ST_I = 0, ST_R = 1, ST_T = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic detIn = 1'b1;
  logic ringReq = 1'b0;
  logic relayEn, offHook, ringTrip;

  int compared = 0;
  int mismatched = 0;
  int tripPulses = 0;
  bit finished = 0;

  // reference model state
  int mState = ST_I;
  int mWin = 0;
  int mLow = 0;
  bit mS1 = 1'b1;
  bit mS2 = 1'b1;
  bit mTrip = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_trip_detector #(.WINDOW_CYCLES(WIN), .SYNC_STAGES(2)) u_ring_trip_detector (
    .clk(clk), .rstN(rstN), .detIn(detIn), .ringReq(ringReq),
    .relayEn(relayEn), .offHook(offHook), .ringTrip(ringTrip)
  );

  function automatic bit isMajority(int lows);
    return (lows * 2) > WIN;
  endfunction

  task automatic checkBit(string tag, string what, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelEdge(bit ringV, bit detV);
    bit sampling, lowS, last, trip;
    int nextState;
    sampling = (mState == ST_R);
    lowS = sampling && !mS2;
    last = sampling && (mWin == WIN - 1);
    trip = sampling && ringV && last && isMajority(mLow + int'(lowS));
    nextState = mState;
    case (mState)
      ST_I: if (ringV) nextState = ST_R;
      ST_R: if (!ringV) nextState = ST_I; else if (trip) nextState = ST_T;
      default: if (!ringV) nextState = ST_I;
    endcase
    if (!sampling || last) begin mWin = 0; mLow = 0; end
    else begin mWin++; mLow += int'(lowS); end
    mState = nextState;
    mTrip = trip;
    mS2 = mS1;
    mS1 = detV;
  endtask

  task automatic tick(bit ringV, bit detV, string tag);
    @(negedge clk);
    ringReq = ringV;
    detIn = detV;
    @(posedge clk);
    modelEdge(ringV, detV);
    #1;
    if (ringTrip === 1'b1) tripPulses++;
    checkBit(tag, "relayEn", relayEn, mState == ST_R);
    checkBit(tag, "offHook", offHook, mState == ST_T);
    checkBit(tag, "ringTrip", ringTrip, mTrip);
  endtask

  // raise ringing at tick 0, detector low on ticks lo..hi, run through tick WIN
  task automatic runWindow(int lo, int hi, string tag);
    for (int t = 0; t <= WIN; t++) tick(1'b1, !(t >= lo && t <= hi), tag);
  endtask

  task automatic idleTicks(int n, string tag);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    checkBit("R1", "relayEn", relayEn, 1'b0);
    checkBit("R1", "offHook", offHook, 1'b0);
    checkBit("R1", "ringTrip", ringTrip, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    idleTicks(4, "R1");

    // R9: low detector while idle has no effect
    for (int i = 0; i < 3 * WIN; i++) tick(1'b0, 1'b0, "R9");
    checkBit("R9", "offHook idle-low", offHook, 1'b0);
    idleTicks(3, "R9");

    // R2: relay on after the first ringing edge
    tick(1'b1, 1'b1, "R2");
    checkBit("R2", "relayEn rise", relayEn, 1'b1);
    for (int t = 1; t <= WIN; t++) tick(1'b1, 1'b1, "R2");
    idleTicks(3, "R2");

    // R5: exact tie (20 of 40 low samples) stays on-hook
    runWindow(19, 38, "R5");
    checkBit("R5", "offHook tie", offHook, 1'b0);
    checkBit("R5", "relayEn tie", relayEn, 1'b1);
    idleTicks(3, "R5");

    // R3: run shifted one cycle late, only 20 lows fall inside the window
    runWindow(19, 39, "R3");
    checkBit("R3", "offHook late run", offHook, 1'b0);
    idleTicks(3, "R3");

    // R5/R6/R7: 21 low samples trip at the window end
    tripPulses = 0;
    runWindow(18, 38, "R5");
    checkBit("R6", "offHook trip", offHook, 1'b1);
    checkBit("R6", "relayEn trip", relayEn, 1'b0);
    checkBit("R7", "ringTrip pulse", ringTrip, 1'b1);
    // R8: latched while request held
    for (int i = 0; i < 50; i++) tick(1'b1, 1'b1, "R8");
    checkBit("R8", "offHook held", offHook, 1'b1);
    checkBit("R8", "relayEn held off", relayEn, 1'b0);
    checkBit("R7", "single pulse", logic'(tripPulses == 1), 1'b1);
    tick(1'b0, 1'b1, "R8");
    checkBit("R8", "offHook released", offHook, 1'b0);
    idleTicks(3, "R8");

    // R10: partial window discarded when the request drops
    for (int t = 0; t < 30; t++) tick(1'b1, 1'b0, "R10");
    idleTicks(2, "R10");
    for (int t = 0; t <= WIN + 5; t++) tick(1'b1, 1'b1, "R10");
    checkBit("R10", "offHook fresh", offHook, 1'b0);
    checkBit("R10", "relayEn fresh", relayEn, 1'b1);
    idleTicks(3, "R10");

    // R4: random duty bursts across several windows
    for (int b = 0; b < 60; b++) begin
      int len = 10 + int'($urandom % 150);
      int pct = int'($urandom % 101);
      for (int i = 0; i < len; i++)
        tick(1'b1, !(int'($urandom % 100) < pct), "R4");
      for (int i = 0, n = 1 + int'($urandom % 5); i < n; i++)
        tick(1'b0, bit'($urandom % 2), "R9");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule